// File: doc/BRIEF.md
# BCD Seven-Segment Glyph Decoder

This block turns a four-bit binary-coded decimal digit into the seven drive lines of a segment display. It is purely combinational. When the enable input is high, the segments that form the glyph for the input value light up. When the enable is low, every segment is dark. All outputs are active high, so a 1 lights a segment.

Two compile-time options change the glyph set. The first gives the digits 6 and 9 their tails: digit 6 also lights the top bar and digit 9 also lights the bottom bar. The second shows the hexadecimal letters A, b, C, d, E and F for the input codes 10 to 15. Without this option those codes blank the display. Display multiplexing and LED drive belong to the surrounding logic.

Top module: `sevenseg_decoder`

## Requirements
- R1: With `en` high and the default options, the codes 0 to 9 light these segments. The output `seg` carries segment a in bit 6 and segments b, c, d, e, f and g in bits 5 down to 0. Segments a to f run clockwise from the top bar and g is the middle bar. The glyphs are 0=abcdef, 1=bc, 2=abdeg, 3=abcdg, 4=bcfg, 5=acdfg, 6=cdefg, 7=abc, 8=abcdefg, 9=abcfg.
- R2: With `en` low, `seg` is 0 for every one of the 16 input codes, whatever options are set.
- R3: With `SHOW_TAILS`=1, code 6 lights acdefg and code 9 lights abcdfg.
- R4: With `SHOW_HEX`=0 and `en` high, the codes 10 to 15 drive `seg` to 0.
- R5: With `SHOW_HEX`=1 and `en` high, the codes 10 to 15 light A=abcefg, b=cdefg, C=adef, d=bcdeg, E=adefg and F=aefg.
- R6: Each option changes only the codes it names. `SHOW_TAILS` alters no code other than 6 and 9, and `SHOW_HEX` alters no code from 0 to 9.
- R7: `seg` follows `en` and `bcd` combinationally, with no clock and no stored state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| en | input | 1 | Active-high enable. When low, all segments are dark. |
| bcd | input | 4 | Digit code. Bit 3 is the most significant bit. |
| seg | output | 7 | Segment drives {a,b,c,d,e,f,g}, MSB first. A 1 lights the segment. |

## Verification
Every result is due in the same cycle as its stimulus, because no register lies between the inputs and `seg`. The bench changes `en` and `bcd` on the falling clock edge and reads `seg` two nanoseconds later, within that same half period. Four instances, one for each option combination, share the inputs. For every code, each output is compared in that sample window against a table the bench holds for that instance's options.

// File: rtl/sevenseg_pkg.sv
package sevenseg_pkg;

    localparam int DIGIT_W = 4;
    localparam int SEG_N   = 7;
    localparam int CODES   = 1 << DIGIT_W;
    localparam int DEC_MAX = 9;

    // a is the most significant bit, g the least
    typedef struct packed {
        logic a;
        logic b;
        logic c;
        logic d;
        logic e;
        logic f;
        logic g;
    } seg_t;

    localparam seg_t SEG_DARK = '0;

    function automatic seg_t mk(input logic [SEG_N-1:0] bits);
        return seg_t'(bits);
    endfunction

    // glyph for a decimal digit, tails optional
    function automatic seg_t decimal_glyph(input logic [DIGIT_W-1:0] v, input bit tails);
        seg_t s;
        case (v)
            4'd0: s = mk(7'b1111110);
            4'd1: s = mk(7'b0110000);
            4'd2: s = mk(7'b1101101);
            4'd3: s = mk(7'b1111001);
            4'd4: s = mk(7'b0110011);
            4'd5: s = mk(7'b1011011);
            4'd6: s = mk(7'b0011111);
            4'd7: s = mk(7'b1110000);
            4'd8: s = mk(7'b1111111);
            4'd9: s = mk(7'b1110011);
            default: s = SEG_DARK;
        endcase
        if (tails && v == 4'd6) s.a = 1'b1;
        if (tails && v == 4'd9) s.d = 1'b1;
        return s;
    endfunction

    // glyph for the letter codes 10..15
    function automatic seg_t letter_glyph(input logic [DIGIT_W-1:0] v);
        seg_t s;
        case (v)
            4'd10: s = mk(7'b1110111);
            4'd11: s = mk(7'b0011111);
            4'd12: s = mk(7'b1001110);
            4'd13: s = mk(7'b0111101);
            4'd14: s = mk(7'b1001111);
            4'd15: s = mk(7'b1000111);
            default: s = SEG_DARK;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/sevenseg_glyph.sv
module sevenseg_glyph
    import sevenseg_pkg::*;
#(
    parameter bit SHOW_TAILS = 1'b0,
    parameter bit SHOW_HEX   = 1'b0
) (
    input  logic [DIGIT_W-1:0] code,
    output seg_t               glyph
);

    logic over_range;
    seg_t dec_glyph;
    seg_t high_glyph;

    assign over_range = (code > DIGIT_W'(DEC_MAX));

    always_comb begin
        dec_glyph = decimal_glyph(code, SHOW_TAILS);
    end

    generate
        if (SHOW_HEX) begin : g_hex
            always_comb high_glyph = letter_glyph(code);
        end else begin : g_blank
            always_comb high_glyph = SEG_DARK;
        end
    endgenerate

    assign glyph = over_range ? high_glyph : dec_glyph;

endmodule

// File: rtl/sevenseg_gate.sv
module sevenseg_gate
    import sevenseg_pkg::*;
(
    input  logic en,
    input  seg_t raw,
    output seg_t drive
);

    logic [SEG_N-1:0] raw_bits;
    logic [SEG_N-1:0] out_bits;

    assign raw_bits = raw;

    generate
        for (genvar i = 0; i < SEG_N; i++) begin : g_seg
            assign out_bits[i] = raw_bits[i] & en;
        end
    endgenerate

    assign drive = seg_t'(out_bits);

endmodule

// File: rtl/sevenseg_decoder.sv
module sevenseg_decoder
    import sevenseg_pkg::*;
#(
    parameter bit SHOW_TAILS = 1'b0,
    parameter bit SHOW_HEX   = 1'b0
) (
    input  logic               en,
    input  logic [DIGIT_W-1:0] bcd,
    output logic [SEG_N-1:0]   seg
);

    seg_t glyph;
    seg_t drive;

    sevenseg_glyph #(
        .SHOW_TAILS (SHOW_TAILS),
        .SHOW_HEX   (SHOW_HEX)
    ) u_glyph (
        .code  (bcd),
        .glyph (glyph)
    );

    sevenseg_gate u_gate (
        .en    (en),
        .raw   (glyph),
        .drive (drive)
    );

    assign seg = drive;

endmodule

// File: rtl/sevenseg_checker.sv
module sevenseg_checker
    import sevenseg_pkg::*;
#(
    parameter bit SHOW_TAILS = 1'b0,
    parameter bit SHOW_HEX   = 1'b0
) (
    input logic               en,
    input logic [DIGIT_W-1:0] bcd,
    input logic [SEG_N-1:0]   seg
);

    always_comb begin
        if (!$isunknown({en, bcd})) begin
            // R2: a low enable darkens every segment
            p_dark_when_off_r2: assert (en || seg == '0);
            // R1: digit 8 lights all segments, digit 1 exactly two
            p_eight_full_r1: assert (!(en && bcd == 4'd8) || seg == 7'h7F);
            p_one_pair_r1: assert (!(en && bcd == 4'd1) || $countones(seg) == 2);
            // R3: top bar of 6 and bottom bar of 9 follow the tail option
            p_tail_six_r3: assert (!(en && bcd == 4'd6) || seg[6] == SHOW_TAILS);
            p_tail_nine_r3: assert (!(en && bcd == 4'd9) || seg[3] == SHOW_TAILS);
            // R4: codes above nine are dark without the hex option
            p_high_blank_r4: assert (!(en && bcd > 4'd9 && !SHOW_HEX) || seg == '0);
            // R5: codes above nine light something with the hex option
            p_high_lit_r5: assert (!(en && bcd > 4'd9 && SHOW_HEX) || seg != '0);
        end
    end

endmodule

bind sevenseg_decoder sevenseg_checker #(
    .SHOW_TAILS (SHOW_TAILS),
    .SHOW_HEX   (SHOW_HEX)
) u_chk (
    .en  (en),
    .bcd (bcd),
    .seg (seg)
);

// File: tb/sim_sevenseg_decoder.sv
`timescale 1ns/1ps
module sim_sevenseg_decoder;

    logic       clk = 1'b0;
    logic       en;
    logic [3:0] bcd;
    logic [6:0] s0, s1, s2, s3;
    int         checks = 0;
    int         errors = 0;
    bit         done   = 1'b0;

    always #4 clk = ~clk;

    // u0 plain, u1 tails, u2 hex, u3 tails and hex
    sevenseg_decoder #(.SHOW_TAILS(1'b0), .SHOW_HEX(1'b0)) u0 (.en(en), .bcd(bcd), .seg(s0));
    sevenseg_decoder #(.SHOW_TAILS(1'b1), .SHOW_HEX(1'b0)) u1 (.en(en), .bcd(bcd), .seg(s1));
    sevenseg_decoder #(.SHOW_TAILS(1'b0), .SHOW_HEX(1'b1)) u2 (.en(en), .bcd(bcd), .seg(s2));
    sevenseg_decoder #(.SHOW_TAILS(1'b1), .SHOW_HEX(1'b1)) u3 (.en(en), .bcd(bcd), .seg(s3));

    function automatic logic [6:0] expect_seg(input int code, input bit tails, input bit hex);
        logic [6:0] r;
        case (code)
            0: r = 7'b1111110;  1: r = 7'b0110000;  2: r = 7'b1101101;
            3: r = 7'b1111001;  4: r = 7'b0110011;  5: r = 7'b1011011;
            6: r = tails ? 7'b1011111 : 7'b0011111;
            7: r = 7'b1110000;  8: r = 7'b1111111;
            9: r = tails ? 7'b1111011 : 7'b1110011;
            10: r = hex ? 7'b1110111 : 7'b0;
            11: r = hex ? 7'b0011111 : 7'b0;
            12: r = hex ? 7'b1001110 : 7'b0;
            13: r = hex ? 7'b0111101 : 7'b0;
            14: r = hex ? 7'b1001111 : 7'b0;
            15: r = hex ? 7'b1000111 : 7'b0;
            default: r = 7'b0;
        endcase
        return r;
    endfunction

    task automatic check(input string req, input int inst, input logic [6:0] act, input logic [6:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s u%0d en=%0b bcd=%0d actual=%b expected=%b", req, inst, en, bcd, act, exp);
        end
    endtask

    // inputs change on the falling edge, outputs read 2 ns later
    task automatic apply(input logic e, input int code);
        @(negedge clk);
        en  = e;
        bcd = 4'(code);
        #2;
    endtask

    task automatic t_idle;
        apply(1'b0, 0);
        check("R2", 0, s0, 7'b0);
        check("R2", 3, s3, 7'b0);
    endtask

    task automatic t_digits_r1;
        for (int c = 0; c <= 9; c++) begin
            apply(1'b1, c);
            check("R1", 0, s0, expect_seg(c, 1'b0, 1'b0));
            check("R6", 2, s2, expect_seg(c, 1'b0, 1'b0));
        end
    endtask

    task automatic t_tails_r3;
        for (int c = 0; c < 16; c++) begin
            apply(1'b1, c);
            check((c == 6 || c == 9) ? "R3" : "R6", 1, s1, expect_seg(c, 1'b1, 1'b0));
            check((c == 6 || c == 9) ? "R3" : "R6", 3, s3, expect_seg(c, 1'b1, 1'b1));
        end
    endtask

    task automatic t_high_blank_r4;
        for (int c = 10; c < 16; c++) begin
            apply(1'b1, c);
            check("R4", 0, s0, 7'b0);
            check("R4", 1, s1, 7'b0);
        end
    endtask

    task automatic t_hex_r5;
        for (int c = 10; c < 16; c++) begin
            apply(1'b1, c);
            check("R5", 2, s2, expect_seg(c, 1'b0, 1'b1));
        end
    endtask

    task automatic t_disable_r2;
        for (int c = 0; c < 16; c++) begin
            apply(1'b0, c);
            check("R2", 0, s0, 7'b0);
            check("R2", 1, s1, 7'b0);
            check("R2", 2, s2, 7'b0);
            check("R2", 3, s3, 7'b0);
        end
    endtask

    // R7: output follows enable toggles with no clock in between
    task automatic t_follow_r7;
        @(negedge clk);
        en = 1'b1; bcd = 4'd8;
        #1 check("R7", 0, s0, 7'b1111111);
        en = 1'b0;
        #1 check("R7", 0, s0, 7'b0);
        en = 1'b1; bcd = 4'd2;
        #1 check("R7", 0, s0, 7'b1101101);
    endtask

    initial begin
        en  = 1'b0;
        bcd = 4'd0;
        t_idle();
        t_digits_r1();
        t_tails_r3();
        t_high_blank_r4();
        t_hex_r5();
        t_disable_r2();
        t_follow_r7();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule